// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised set of external interrupt lines and delivers each one to exactly one of several processor contexts. Every line passes a two-flop synchronizer, then a per-source condition stage that treats it as a level (high or low) or as an edge (rising, falling, or both). Each source has a pending state, a mask bit and a route register. A context's interrupt output is raised whenever at least one source routed to it is both pending and unmasked.

Software reaches the block over a simple word-addressed register bus. Writes take effect on the next clock edge and reads are combinational. Configuration words hold one bit per source for polarity, trigger type and dual-edge enable. The mask is changed only through two write-one ports, one that enables and one that disables. A single edge-control word can either raise or acknowledge the edge latch of one source. For each context a read-only pair of outputs gives the lowest-numbered source that is currently asserting it, together with a valid flag.

Register word addresses: 0x00 configuration (read-only), 0x01 polarity, 0x02 trigger, 0x03 dual-edge, 0x04 mask-enable port (write-only), 0x05 mask-disable port (write-only), 0x06 mask readback, 0x07 pending readback, 0x08 edge control (write-only), and 0x20+s route of source s. Bit s of every per-source word belongs to source s. Unmapped reads return zero.

Top module: `irq_share_ctrl`

## Requirements
- R1: A write to 0x04 sets every mask bit whose data bit is 1. A write to 0x05 clears every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged, and the result is visible at 0x06 after the write cycle.
- R2: A write to 0x08 with bits 30:8 zero selects the source given in bits 7:0. If bit 31 is 1, the edge latch of that source is set. If bit 31 is 0, the latch is cleared. Only edge-triggered sources keep the latch, so the write has no effect on a level source.
- R3: Polarity bit 1 means active high or rising, 0 means active low or falling. Trigger bit 1 means edge, 0 means level. A level source's pending bit follows the polarity-corrected synchronized input. An edge source latches pending on its active edge and holds it until acknowledged.
- R4: When a source is edge-triggered and its dual-edge bit is 1, both rising and falling transitions latch pending, whatever its polarity bit.
- R5: The route word at 0x20+s holds the context number of source s in its low bits and reads back that value. Rewriting it moves the source's effect to the new context.
- R6: Context output c is 1 exactly when some source is pending, unmasked and routed to c.
- R7: After reset every source is level-triggered, active high, not dual-edge, masked, and routed to context 0.
- R8: The configuration word at 0x00 is read-only. Bits 7:0 give sources/8 − 1 and bits 15:8 give contexts − 1.
- R9: For each context the top-source output gives the lowest-numbered source that is pending, unmasked and routed there, with a valid flag that matches that context's output.
- R10: If a synchronized active edge and an acknowledge write for the same source fall in the same cycle, the latch ends set.
- R11: An input change reaches a level source's pending bit after two clock edges, through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqIn | input | NUM_SRC | Asynchronous interrupt lines |
| ctxIrq | output | NUM_CTX | One interrupt output per context |
| ctxTopValid | output | NUM_CTX | Some source is asserting the context |
| ctxTopId | output | NUM_CTX*SRC_W | Lowest asserting source number per context |

## Verification
The clash that matters is a hardware edge arriving in the same cycle as a software acknowledge for that source. The latch is first set through the edge-control word. The line is then raised so that the synchronized edge is detected in exactly the cycle in which the acknowledge write is sampled. The pending readback must still show the source set afterwards, and a second acknowledge with no edge present must clear it.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] ADDR_CFG   = 8'h00;
  localparam logic [BUS_AW-1:0] ADDR_POL   = 8'h01;
  localparam logic [BUS_AW-1:0] ADDR_TRIG  = 8'h02;
  localparam logic [BUS_AW-1:0] ADDR_DUAL  = 8'h03;
  localparam logic [BUS_AW-1:0] ADDR_MSET  = 8'h04;
  localparam logic [BUS_AW-1:0] ADDR_MCLR  = 8'h05;
  localparam logic [BUS_AW-1:0] ADDR_MASK  = 8'h06;
  localparam logic [BUS_AW-1:0] ADDR_PEND  = 8'h07;
  localparam logic [BUS_AW-1:0] ADDR_EDGE  = 8'h08;
  localparam logic [2:0]        ROUTE_PAGE = 3'b001;

  // strobes from the bus decoder to the datapath
  typedef struct packed {
    logic       wrPol;
    logic       wrTrig;
    logic       wrDual;
    logic       wrMaskSet;
    logic       wrMaskClr;
    logic       wrRoute;
    logic       edgeSet;
    logic       edgeClr;
    logic [7:0] srcSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_share_ctrl_bus.sv
module irq_share_ctrl_bus
  import irq_share_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic                     busWrEn,
  input  logic [BUS_AW-1:0]        busAddr,
  input  logic [BUS_DW-1:0]        busWrData,
  output logic [BUS_DW-1:0]        busRdData,
  output ctrlStrobe_t              strobe,
  input  logic [NUM_SRC-1:0]       polVec,
  input  logic [NUM_SRC-1:0]       trigVec,
  input  logic [NUM_SRC-1:0]       dualVec,
  input  logic [NUM_SRC-1:0]       maskVec,
  input  logic [NUM_SRC-1:0]       pendVec,
  input  logic [NUM_SRC*CTX_W-1:0] routeFlat
);

  localparam logic [7:0] CFG_SRC = 8'(NUM_SRC / 8 - 1);
  localparam logic [7:0] CFG_CTX = 8'(NUM_CTX - 1);

  logic isRoute;
  logic edgeOk;

  assign isRoute = (busAddr[7:5] == ROUTE_PAGE);
  assign edgeOk  = busWrEn && (busAddr == ADDR_EDGE) && (busWrData[30:8] == '0);

  always_comb begin
    strobe           = '0;
    strobe.wrPol     = busWrEn && (busAddr == ADDR_POL);
    strobe.wrTrig    = busWrEn && (busAddr == ADDR_TRIG);
    strobe.wrDual    = busWrEn && (busAddr == ADDR_DUAL);
    strobe.wrMaskSet = busWrEn && (busAddr == ADDR_MSET);
    strobe.wrMaskClr = busWrEn && (busAddr == ADDR_MCLR);
    strobe.wrRoute   = busWrEn && isRoute;
    strobe.edgeSet   = edgeOk && busWrData[31];
    strobe.edgeClr   = edgeOk && !busWrData[31];
    strobe.srcSel    = isRoute ? {3'b000, busAddr[4:0]} : busWrData[7:0];
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_CFG:  busRdData = {16'h0000, CFG_CTX, CFG_SRC};
      ADDR_POL:  busRdData[NUM_SRC-1:0] = polVec;
      ADDR_TRIG: busRdData[NUM_SRC-1:0] = trigVec;
      ADDR_DUAL: busRdData[NUM_SRC-1:0] = dualVec;
      ADDR_MASK: busRdData[NUM_SRC-1:0] = maskVec;
      ADDR_PEND: busRdData[NUM_SRC-1:0] = pendVec;
      default: begin
        if (isRoute) begin
          for (int s = 0; s < NUM_SRC; s++) begin
            if (busAddr[4:0] == 5'(s)) busRdData[CTX_W-1:0] = routeFlat[s*CTX_W +: CTX_W];
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/irq_share_datapath.sv
module irq_share_datapath
  import irq_share_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         irqIn,
  input  ctrlStrobe_t                strobe,
  input  logic [NUM_SRC-1:0]         wrBits,
  output logic [NUM_SRC-1:0]         polVec,
  output logic [NUM_SRC-1:0]         trigVec,
  output logic [NUM_SRC-1:0]         dualVec,
  output logic [NUM_SRC-1:0]         maskVec,
  output logic [NUM_SRC-1:0]         pendVec,
  output logic [NUM_SRC*CTX_W-1:0]   routeFlat,
  output logic [NUM_CTX*NUM_SRC-1:0] ctxReq,
  output logic [NUM_CTX-1:0]         ctxIrq
);

  logic [NUM_SRC-1:0] syncA, syncB, syncPrev;
  logic [NUM_SRC-1:0] latchQ, latchD;
  logic [NUM_SRC-1:0] riseEv, fallEv, edgeEv;
  logic [NUM_SRC-1:0] selHot;
  logic [CTX_W-1:0]   routeQ [NUM_SRC];

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= irqIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  // configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polVec  <= '1;
      trigVec <= '0;
      dualVec <= '0;
      maskVec <= '0;
    end else begin
      if (strobe.wrPol)     polVec  <= wrBits;
      if (strobe.wrTrig)    trigVec <= wrBits;
      if (strobe.wrDual)    dualVec <= wrBits;
      if (strobe.wrMaskSet) maskVec <= maskVec | wrBits;
      else if (strobe.wrMaskClr) maskVec <= maskVec & ~wrBits;
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) selHot[s] = (strobe.srcSel == 8'(s));
  end

  assign riseEv = syncB & ~syncPrev;
  assign fallEv = ~syncB & syncPrev;
  assign edgeEv = (dualVec & (riseEv | fallEv)) |
                  (~dualVec & ((polVec & riseEv) | (~polVec & fallEv)));

  // a fresh edge outranks a same-cycle acknowledge
  always_comb begin
    latchD = latchQ;
    if (strobe.edgeClr) latchD = latchD & ~selHot;
    if (strobe.edgeSet) latchD = latchD | selHot;
    latchD = (latchD | edgeEv) & trigVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '0;
    else       latchQ <= latchD;
  end

  assign pendVec = (trigVec & latchQ) | (~trigVec & ~(syncB ^ polVec));

  // route registers, one context index per source
  genvar gs;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : gRoute
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) routeQ[gs] <= '0;
        else if (strobe.wrRoute && selHot[gs]) routeQ[gs] <= wrBits[CTX_W-1:0];
      end
      assign routeFlat[gs*CTX_W +: CTX_W] = routeQ[gs];
    end
  endgenerate

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CTX; gc++) begin : gCtx
      logic [NUM_SRC-1:0] routedHere;
      always_comb begin
        for (int s = 0; s < NUM_SRC; s++) routedHere[s] = (routeQ[s] == CTX_W'(gc));
      end
      assign ctxReq[gc*NUM_SRC +: NUM_SRC] = pendVec & maskVec & routedHere;
      assign ctxIrq[gc] = |(pendVec & maskVec & routedHere);
    end
  endgenerate

endmodule

// File: rtl/irq_share_prio.sv
module irq_share_prio #(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               valid,
  output logic [SRC_W-1:0]   topId
);

  always_comb begin
    topId = '0;
    valid = 1'b0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (req[s]) begin
        topId = SRC_W'(s);
        valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_share_ctrl.sv
module irq_share_ctrl
  import irq_share_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic [BUS_AW-1:0]        busAddr,
  input  logic [BUS_DW-1:0]        busWrData,
  output logic [BUS_DW-1:0]        busRdData,
  input  logic [NUM_SRC-1:0]       irqIn,
  output logic [NUM_CTX-1:0]       ctxIrq,
  output logic [NUM_CTX-1:0]       ctxTopValid,
  output logic [NUM_CTX*SRC_W-1:0] ctxTopId
);

  ctrlStrobe_t              strobe;
  logic [NUM_SRC-1:0]       polVec, trigVec, dualVec, maskVec, pendVec;
  logic [NUM_SRC*CTX_W-1:0] routeFlat;
  logic [NUM_CTX*NUM_SRC-1:0] ctxReq;

  irq_share_ctrl_bus #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) uBus (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .strobe(strobe), .polVec(polVec), .trigVec(trigVec), .dualVec(dualVec),
    .maskVec(maskVec), .pendVec(pendVec), .routeFlat(routeFlat)
  );

  irq_share_datapath #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) uDp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobe(strobe),
    .wrBits(busWrData[NUM_SRC-1:0]),
    .polVec(polVec), .trigVec(trigVec), .dualVec(dualVec), .maskVec(maskVec),
    .pendVec(pendVec), .routeFlat(routeFlat), .ctxReq(ctxReq), .ctxIrq(ctxIrq)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CTX; gc++) begin : gPrio
      irq_share_prio #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) uPrio (
        .req(ctxReq[gc*NUM_SRC +: NUM_SRC]),
        .valid(ctxTopValid[gc]),
        .topId(ctxTopId[gc*SRC_W +: SRC_W])
      );
    end
  endgenerate

endmodule

// File: rtl/irq_share_ctrl_chk.sv
module irq_share_ctrl_chk
  import irq_share_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busWrEn,
  input logic [BUS_AW-1:0]        busAddr,
  input logic [BUS_DW-1:0]        busWrData,
  input logic [BUS_DW-1:0]        busRdData,
  input logic [NUM_SRC-1:0]       irqIn,
  input logic [NUM_CTX-1:0]       ctxIrq,
  input logic [NUM_CTX-1:0]       ctxTopValid,
  input logic [NUM_CTX*SRC_W-1:0] ctxTopId,
  input logic [NUM_SRC-1:0]       maskVec,
  input logic [NUM_SRC-1:0]       pendVec,
  input logic [NUM_SRC-1:0]       polVec,
  input logic [NUM_SRC-1:0]       trigVec,
  input logic [NUM_SRC-1:0]       dualVec
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_mask_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MSET) |=>
      ((maskVec & $past(busWrData[NUM_SRC-1:0])) == $past(busWrData[NUM_SRC-1:0])));

  assert_mask_clr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MCLR) |=> ((maskVec & $past(busWrData[NUM_SRC-1:0])) == '0));

  assert_mask_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && (busAddr == ADDR_MSET || busAddr == ADDR_MCLR)) |=> $stable(maskVec));

  assert_edge_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_EDGE && busWrData[31] && busWrData[30:8] == '0 &&
     busWrData[7:0] < 8'(NUM_SRC) && trigVec[busWrData[SRC_W-1:0]]) |=>
      pendVec[$past(busWrData[SRC_W-1:0])]);

  assert_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (maskVec == '0 && trigVec == '0 && dualVec == '0 && polVec == '1));

  assert_cfg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CFG) |-> (busRdData[15:0] == {8'(NUM_CTX - 1), 8'(NUM_SRC / 8 - 1)}));

  assert_level_sync_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |->
      ((pendVec & ~trigVec) == (~($past(irqIn, 2) ^ polVec) & ~trigVec)));

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CTX; gc++) begin : gCtxChk
      assert_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
        ctxIrq[gc] |-> (pendVec[ctxTopId[gc*SRC_W +: SRC_W]] && maskVec[ctxTopId[gc*SRC_W +: SRC_W]]));
      assert_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
        ctxTopValid[gc] == ctxIrq[gc]);
    end
  endgenerate

endmodule

bind irq_share_ctrl irq_share_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
  .busRdData(busRdData), .irqIn(irqIn), .ctxIrq(ctxIrq), .ctxTopValid(ctxTopValid),
  .ctxTopId(ctxTopId), .maskVec(maskVec), .pendVec(pendVec), .polVec(polVec),
  .trigVec(trigVec), .dualVec(dualVec)
);

// File: tb/sim_irq_share_ctrl.sv
module sim_irq_share_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NC = 4;
  localparam int SW = 4;
  localparam int NV = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [NS-1:0] irqIn = '0;
  logic [NC-1:0] ctxIrq;
  logic [NC-1:0] ctxTopValid;
  logic [NC*SW-1:0] ctxTopId;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_share_ctrl #(.NUM_SRC(NS), .NUM_CTX(NC)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqIn(irqIn), .ctxIrq(ctxIrq), .ctxTopValid(ctxTopValid),
    .ctxTopId(ctxTopId)
  );

  // {req, isRead, addr, data, expected}
  localparam logic [76:0] VEC [NV] = '{
    {4'd8, 1'b1, 8'h00, 32'h0, 32'h0000_0301},   // R8 config word
    {4'd7, 1'b1, 8'h06, 32'h0, 32'h0000_0000},   // R7 mask after reset
    {4'd7, 1'b1, 8'h01, 32'h0, 32'h0000_FFFF},   // R7 polarity after reset
    {4'd7, 1'b1, 8'h02, 32'h0, 32'h0000_0000},   // R7 trigger after reset
    {4'd1, 1'b0, 8'h04, 32'h0000_0011, 32'h0},   // R1 set 0,4
    {4'd1, 1'b1, 8'h06, 32'h0, 32'h0000_0011},
    {4'd1, 1'b0, 8'h04, 32'h0000_0100, 32'h0},   // R1 set 8, others kept
    {4'd1, 1'b1, 8'h06, 32'h0, 32'h0000_0111},
    {4'd1, 1'b0, 8'h05, 32'h0000_0001, 32'h0},   // R1 clear 0
    {4'd1, 1'b1, 8'h06, 32'h0, 32'h0000_0110},
    {4'd1, 1'b0, 8'h05, 32'h0000_0000, 32'h0},   // R1 zero clear no effect
    {4'd1, 1'b1, 8'h06, 32'h0, 32'h0000_0110},
    {4'd3, 1'b0, 8'h02, 32'h0000_00F0, 32'h0},   // R3 sources 4..7 edge
    {4'd3, 1'b1, 8'h02, 32'h0, 32'h0000_00F0},
    {4'd2, 1'b0, 8'h08, 32'h8000_0005, 32'h0},   // R2 raise source 5
    {4'd2, 1'b1, 8'h07, 32'h0, 32'h0000_0020},
    {4'd2, 1'b0, 8'h08, 32'h0000_0005, 32'h0},   // R2 acknowledge source 5
    {4'd2, 1'b1, 8'h07, 32'h0, 32'h0000_0000},
    {4'd2, 1'b0, 8'h08, 32'h8000_0002, 32'h0},   // R2 level source keeps no latch
    {4'd2, 1'b1, 8'h07, 32'h0, 32'h0000_0000},
    {4'd5, 1'b0, 8'h23, 32'h0000_0002, 32'h0},   // R5 route source 3 to context 2
    {4'd5, 1'b1, 8'h23, 32'h0, 32'h0000_0002},
    {4'd8, 1'b0, 8'h00, 32'h0000_FFFF, 32'h0},   // R8 config is read-only
    {4'd8, 1'b1, 8'h00, 32'h0, 32'h0000_0301}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic pendBit(input int s, input logic exp, input string req);
    logic [31:0] v;
    busRead(8'h07, v);
    check(req, {31'd0, v[s]}, {31'd0, exp});
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        busRead(VEC[i][71:64], rd);
        check($sformatf("R%0d vec%0d", VEC[i][76:73], i), rd, VEC[i][31:0]);
      end else begin
        busWrite(VEC[i][71:64], VEC[i][63:32]);
      end
    end

    // R11: level source 0 passes two flops
    @(negedge clk); irqIn[0] = 1'b1;
    @(negedge clk); #1 busAddr = 8'h07;
    #1 check("R11 one edge", {31'd0, busRdData[0]}, 32'd0);
    @(negedge clk); #1 check("R11 two edges", {31'd0, busRdData[0]}, 32'd1);

    // R3: active-low level source 1 with input low is pending
    busWrite(8'h01, 32'h0000_FFFD);
    repeat (3) @(negedge clk);
    busRead(8'h07, rd);
    check("R3 level low", rd & 32'h3, 32'h3);

    // R6/R9/R5: level source 8, unmasked, context 0
    irqIn[8] = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 ctx0 on", {28'd0, ctxIrq}, 32'h1);
    check("R9 ctx0 top", {28'd0, ctxTopId[0 +: SW]}, 32'd8);
    busWrite(8'h28, 32'd3);
    #1 check("R5 moved", {28'd0, ctxIrq}, 32'h8);
    check("R9 ctx3 top", {28'd0, ctxTopId[3*SW +: SW]}, 32'd8);
    busWrite(8'h05, 32'h0000_0100);
    #1 check("R6 masked off", {28'd0, ctxIrq}, 32'h0);

    // R3: rising edge source 4 latches and holds
    irqIn[4] = 1'b1;
    repeat (4) @(negedge clk);
    pendBit(4, 1'b1, "R3 rise latch");
    irqIn[4] = 1'b0;
    repeat (4) @(negedge clk);
    pendBit(4, 1'b1, "R3 hold after drop");
    busWrite(8'h08, 32'h0000_0004);
    pendBit(4, 1'b0, "R2 ack source 4");

    // R3: falling edge source 6
    busWrite(8'h01, 32'h0000_FFBD);
    irqIn[6] = 1'b1;
    repeat (4) @(negedge clk);
    pendBit(6, 1'b0, "R3 rise ignored on falling");
    irqIn[6] = 1'b0;
    repeat (4) @(negedge clk);
    pendBit(6, 1'b1, "R3 fall latch");
    busWrite(8'h08, 32'h0000_0006);

    // R4: dual edge source 7
    busWrite(8'h03, 32'h0000_0080);
    irqIn[7] = 1'b1;
    repeat (4) @(negedge clk);
    pendBit(7, 1'b1, "R4 dual rise");
    busWrite(8'h08, 32'h0000_0007);
    irqIn[7] = 1'b0;
    repeat (4) @(negedge clk);
    pendBit(7, 1'b1, "R4 dual fall");
    busWrite(8'h08, 32'h0000_0007);

    // R9: priority inside context 1
    busWrite(8'h24, 32'd1);
    busWrite(8'h25, 32'd1);
    busWrite(8'h04, 32'h0000_0030);
    busWrite(8'h08, 32'h8000_0005);
    #1 check("R9 single", {27'd0, ctxTopValid[1], ctxTopId[SW +: SW]}, {27'd0, 1'b1, 4'd5});
    busWrite(8'h08, 32'h8000_0004);
    #1 check("R9 lowest wins", {28'd0, ctxTopId[SW +: SW]}, 32'd4);
    busWrite(8'h08, 32'h0000_0004);
    #1 check("R9 next", {28'd0, ctxTopId[SW +: SW]}, 32'd5);
    busWrite(8'h08, 32'h0000_0005);
    #1 check("R9 none", {31'd0, ctxTopValid[1]}, 32'd0);

    // R10: hardware edge and acknowledge in one cycle
    busWrite(8'h08, 32'h8000_0004);
    @(negedge clk); irqIn[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 8'h08; busWrData = 32'h0000_0004;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
    pendBit(4, 1'b1, "R10 edge beats ack");
    busWrite(8'h08, 32'h0000_0004);
    pendBit(4, 1'b0, "R10 later ack clears");

    // R7: second reset
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    busRead(8'h06, rd); check("R7 mask", rd, 32'h0);
    busRead(8'h28, rd); check("R7 route", rd, 32'h0);
    busRead(8'h03, rd); check("R7 dual", rd, 32'h0);
    check("R7 outputs", {28'd0, ctxIrq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule